// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block is the register-stack core of a floating-point unit. It keeps eight data registers, each `DATA_W` bits wide (80 by default). They are reached through a 3-bit top-of-stack pointer, so relative entry STi lives in physical register `(topPtr + i) mod 8`. Each register carries an empty flag. The flags are presented as a 2-bit tag per register: `11` means empty and `00` means valid. Register p's tag sits at `tagWord[2p+1:2p]`. The block does no arithmetic. It only stores values, moves the pointer, tracks the tags and detects stack faults.

Commands arrive one per cycle. Each command is a valid strobe, a 3-bit opcode, a 3-bit relative index and a data word. Opcodes: 0 push data, 1 push copy of STi, 2 store-then-pop, 3 exchange, 4 read STi, 5 write STi, 6 initialize, 7 clear exceptions. Every state change and every output is registered, so the result of a command is visible on the outputs one clock after it is accepted.

The fault flags are sticky. A faulting command leaves the pointer, the tags and the data as they were. It sets the stack-fault flag and the invalid-operation flag, and it loads the direction bit C1. C1 is 1 when a push found its target register occupied (overflow) and 0 when an empty register was read (underflow).

Top module: `fpRegStack`

## Requirements
- R1: Reset and the initialize command (opcode 6) set `topPtr` to 0, set `tagWord` to 0xFFFF and clear stack-fault, C1 and invalid-operation.
- R2: Push data (opcode 0) decrements `topPtr` modulo 8. It writes `cmdData` to the physical register the new pointer selects and sets that register's tag to `00`.
- R3: Read (opcode 4) returns STi, the physical register `(topPtr + i) mod 8`, on `rdData` one cycle later, with `rdValid` high for that one cycle only.
- R4: Push copy (opcode 1) resolves its source STi against the pointer before the decrement. With index 0 it therefore duplicates the top entry.
- R5: Store-then-pop (opcode 2) returns ST0 on `rdData`. When the index is nonzero it also copies ST0 into STi. It then marks the old top register empty and increments `topPtr`. With index 0 the top value is simply discarded.
- R6: Exchange (opcode 3) swaps ST0 with STi, with index 0 selecting ST1. It always leaves C1 at 0.
- R7: Write (opcode 5) places `cmdData` in STi and marks it valid. It leaves `topPtr` unchanged and raises no fault.
- R8: A push (opcode 0 or 1) whose target register is not empty is an overflow. It sets stack-fault, invalid-operation and C1=1, and it changes no pointer, tag or data.
- R9: Reading an empty register is an underflow. This covers an empty STi for read or push copy, an empty ST0 for store-then-pop, and an empty ST0 or partner for exchange. It sets stack-fault and invalid-operation with C1=0, and it changes nothing else.
- R10: When a push copy meets an occupied target and an empty source in the same cycle, overflow wins and C1 reads 1.
- R11: Stack-fault and invalid-operation stay set until a clear-exceptions command (opcode 7), which clears both and leaves C1 as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe, one command per cycle |
| cmdOp | input | 3 | Opcode (0 push data … 7 clear exceptions) |
| cmdIdx | input | 3 | Relative register index i of STi |
| cmdData | input | DATA_W | Data for push data and write |
| rdData | output | DATA_W | Registered value from read or store-then-pop |
| rdValid | output | 1 | One-cycle pulse marking new `rdData` |
| topPtr | output | 3 | Top-of-stack pointer |
| tagWord | output | 16 | 2-bit tag per physical register, `11` empty, `00` valid |
| stackFault | output | 1 | Sticky stack-fault flag |
| c1Flag | output | 1 | Direction bit: 1 overflow, 0 underflow |
| invalidOp | output | 1 | Sticky invalid-operation flag |

## Verification
A push copy checks two things at once: that its target is free and that its source holds data. Both faults can therefore arise in a single cycle. The bench provokes this by writing into physical register 7 while the stack is otherwise empty, then pushing a copy of the empty ST3. The target (register 7) is occupied and the source (register 3) is empty. The outputs must then show the overflow direction (C1=1), the pointer still at 0 and the tag word unchanged. An ordering that favours underflow is exposed by a C1 of 0.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  localparam int STK_DEPTH = 8;
  localparam int STK_PW    = $clog2(STK_DEPTH);
  localparam int TAG_W     = 2;

  typedef logic [STK_PW-1:0] stkPtr_t;

  typedef enum logic [2:0] {
    OP_PUSH_EXT  = 3'd0,
    OP_PUSH_REG  = 3'd1,
    OP_POP_STORE = 3'd2,
    OP_XCHG      = 3'd3,
    OP_READ      = 3'd4,
    OP_WRITE     = 3'd5,
    OP_INIT      = 3'd6,
    OP_CLEX      = 3'd7
  } stkOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    wrEn;
    logic    wrFromExt;
    stkPtr_t wrAddr;
    stkPtr_t srcAddr;
    logic    swapEn;
    stkPtr_t swapA;
    stkPtr_t swapB;
    logic    clrEn;
    stkPtr_t clrAddr;
    logic    capEn;
    logic    initEn;
  } stkStrobe_t;
endpackage

// File: rtl/fpstk_data.sv
module fpstk_data
  import fpstk_pkg::*;
#(
  parameter int DATA_W = 80
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  stkStrobe_t           stb,
  input  logic [DATA_W-1:0]    extData,
  output logic [STK_DEPTH-1:0] emptyVec,
  output logic [DATA_W-1:0]    rdData
);
  logic [DATA_W-1:0] regFile [STK_DEPTH];
  logic [DATA_W-1:0] srcVal;
  logic [DATA_W-1:0] wrVal;

  assign srcVal = regFile[stb.srcAddr];
  assign wrVal  = stb.wrFromExt ? extData : srcVal;

  for (genvar gi = 0; gi < STK_DEPTH; gi++) begin : g_entry
    localparam stkPtr_t SLOT = stkPtr_t'(gi);

    always_ff @(posedge clk) begin
      if (stb.swapEn && stb.swapA == SLOT)
        regFile[gi] <= regFile[stb.swapB];
      else if (stb.swapEn && stb.swapB == SLOT)
        regFile[gi] <= regFile[stb.swapA];
      else if (stb.wrEn && stb.wrAddr == SLOT)
        regFile[gi] <= wrVal;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        emptyVec[gi] <= 1'b1;
      else if (stb.initEn)
        emptyVec[gi] <= 1'b1;
      else if (stb.wrEn && stb.wrAddr == SLOT)
        emptyVec[gi] <= 1'b0;
      else if (stb.clrEn && stb.clrAddr == SLOT)
        emptyVec[gi] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (stb.capEn) rdData <= srcVal;
  end
endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
  import fpstk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdOp,
  input  stkPtr_t              cmdIdx,
  input  logic [STK_DEPTH-1:0] emptyVec,
  output stkStrobe_t           stb,
  output stkPtr_t              topPtr,
  output logic                 stackFault,
  output logic                 c1Flag,
  output logic                 invalidOp,
  output logic                 rdValid
);
  stkOp_e  op;
  stkPtr_t stSel, pushTgt, xIdx, xSel;
  logic    topEmpty, selEmpty, tgtBusy, xEmpty;
  logic    ovf, unf, fault;

  assign op       = stkOp_e'(cmdOp);
  assign stSel    = topPtr + cmdIdx;
  assign pushTgt  = topPtr - 1'b1;
  assign xIdx     = (cmdIdx == '0) ? stkPtr_t'(1) : cmdIdx;
  assign xSel     = topPtr + xIdx;
  assign topEmpty = emptyVec[topPtr];
  assign selEmpty = emptyVec[stSel];
  assign tgtBusy  = !emptyVec[pushTgt];
  assign xEmpty   = emptyVec[xSel];

  // Fault detection; overflow takes precedence over underflow
  always_comb begin
    ovf = 1'b0;
    unf = 1'b0;
    if (cmdValid) begin
      case (op)
        OP_PUSH_EXT:  ovf = tgtBusy;
        OP_PUSH_REG: begin
          ovf = tgtBusy;
          unf = !tgtBusy && selEmpty;
        end
        OP_POP_STORE: unf = topEmpty;
        OP_XCHG:      unf = topEmpty || xEmpty;
        OP_READ:      unf = selEmpty;
        default: ;
      endcase
    end
  end
  assign fault = ovf || unf;

  // Datapath strobes, issued only for fault-free commands
  always_comb begin
    stb = '0;
    if (cmdValid && !fault) begin
      case (op)
        OP_PUSH_EXT: begin
          stb.wrEn      = 1'b1;
          stb.wrFromExt = 1'b1;
          stb.wrAddr    = pushTgt;
        end
        OP_PUSH_REG: begin
          stb.wrEn    = 1'b1;
          stb.wrAddr  = pushTgt;
          stb.srcAddr = stSel;
        end
        OP_POP_STORE: begin
          stb.wrEn    = (cmdIdx != '0);
          stb.wrAddr  = stSel;
          stb.srcAddr = topPtr;
          stb.capEn   = 1'b1;
          stb.clrEn   = 1'b1;
          stb.clrAddr = topPtr;
        end
        OP_XCHG: begin
          stb.swapEn = 1'b1;
          stb.swapA  = topPtr;
          stb.swapB  = xSel;
        end
        OP_READ: begin
          stb.capEn   = 1'b1;
          stb.srcAddr = stSel;
        end
        OP_WRITE: begin
          stb.wrEn      = 1'b1;
          stb.wrFromExt = 1'b1;
          stb.wrAddr    = stSel;
        end
        OP_INIT: stb.initEn = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topPtr     <= '0;
      stackFault <= 1'b0;
      c1Flag     <= 1'b0;
      invalidOp  <= 1'b0;
      rdValid    <= 1'b0;
    end else begin
      rdValid <= cmdValid && !fault && (op == OP_READ || op == OP_POP_STORE);
      if (cmdValid) begin
        if (op == OP_INIT) begin
          topPtr     <= '0;
          stackFault <= 1'b0;
          c1Flag     <= 1'b0;
          invalidOp  <= 1'b0;
        end else if (op == OP_CLEX) begin
          stackFault <= 1'b0;
          invalidOp  <= 1'b0;
        end else if (fault) begin
          stackFault <= 1'b1;
          invalidOp  <= 1'b1;
          c1Flag     <= ovf;
        end else begin
          case (op)
            OP_PUSH_EXT, OP_PUSH_REG: topPtr <= pushTgt;
            OP_POP_STORE:             topPtr <= topPtr + 1'b1;
            OP_XCHG:                  c1Flag <= 1'b0;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/fpRegStack.sv
module fpRegStack
  import fpstk_pkg::*;
#(
  parameter int DATA_W = 80
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdValid,
  input  logic [2:0]                 cmdOp,
  input  logic [STK_PW-1:0]          cmdIdx,
  input  logic [DATA_W-1:0]          cmdData,
  output logic [DATA_W-1:0]          rdData,
  output logic                       rdValid,
  output logic [STK_PW-1:0]          topPtr,
  output logic [TAG_W*STK_DEPTH-1:0] tagWord,
  output logic                       stackFault,
  output logic                       c1Flag,
  output logic                       invalidOp
);
  stkStrobe_t           stb;
  logic [STK_DEPTH-1:0] emptyVec;

  fpstk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .cmdIdx     (cmdIdx),
    .emptyVec   (emptyVec),
    .stb        (stb),
    .topPtr     (topPtr),
    .stackFault (stackFault),
    .c1Flag     (c1Flag),
    .invalidOp  (invalidOp),
    .rdValid    (rdValid)
  );

  fpstk_data #(.DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .extData  (cmdData),
    .emptyVec (emptyVec),
    .rdData   (rdData)
  );

  for (genvar gi = 0; gi < STK_DEPTH; gi++) begin : g_tag
    assign tagWord[gi*TAG_W +: TAG_W] = {TAG_W{emptyVec[gi]}};
  end
endmodule

// File: rtl/fpRegStack_chk.sv
module fpRegStack_chk
  import fpstk_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic                       cmdValid,
  input logic [2:0]                 cmdOp,
  input logic [STK_PW-1:0]          topPtr,
  input logic [TAG_W*STK_DEPTH-1:0] tagWord,
  input logic                       stackFault,
  input logic                       c1Flag,
  input logic                       invalidOp
);
  stkPtr_t           tgt;
  logic [STK_PW:0]   tgtBit, topBit;
  logic              tgtFree, topFree;

  assign tgt     = topPtr - 1'b1;
  assign tgtBit  = {tgt, 1'b0};
  assign topBit  = {topPtr, 1'b0};
  assign tgtFree = tagWord[tgtBit];
  assign topFree = tagWord[topBit];

  AST_INIT_STATE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp == OP_INIT |=> topPtr == '0 && (&tagWord) && !stackFault && !invalidOp); // R1

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp == OP_PUSH_EXT && tgtFree |=> topPtr == $past(tgt) && !topFree); // R2

  AST_POP_INC: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp == OP_POP_STORE && !topFree |=> topPtr == $past(topPtr) + 1'b1); // R5

  AST_XCHG_C1: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp == OP_XCHG |=> !c1Flag); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp == OP_PUSH_EXT && !tgtFree
    |=> stackFault && c1Flag && invalidOp && topPtr == $past(topPtr)); // R8

  AST_POP_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp == OP_POP_STORE && topFree
    |=> stackFault && !c1Flag && invalidOp && topPtr == $past(topPtr)); // R9

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    stackFault && !(cmdValid && (cmdOp == OP_INIT || cmdOp == OP_CLEX)) |=> stackFault); // R11

  AST_CLEX_KEEP_C1: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp == OP_CLEX |=> !stackFault && !invalidOp && c1Flag == $past(c1Flag)); // R11
endmodule

bind fpRegStack fpRegStack_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .cmdOp      (cmdOp),
  .topPtr     (topPtr),
  .tagWord    (tagWord),
  .stackFault (stackFault),
  .c1Flag     (c1Flag),
  .invalidOp  (invalidOp)
);

// File: tb/fpRegStack_tb.sv
module fpRegStack_tb;
  localparam int DW = 80;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [2:0]    cmdOp = '0;
  logic [2:0]    cmdIdx = '0;
  logic [DW-1:0] cmdData = '0;
  logic [DW-1:0] rdData;
  logic          rdValid;
  logic [2:0]    topPtr;
  logic [15:0]   tagWord;
  logic          stackFault, c1Flag, invalidOp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fpRegStack u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdIdx(cmdIdx),
    .cmdData(cmdData), .rdData(rdData), .rdValid(rdValid), .topPtr(topPtr),
    .tagWord(tagWord), .stackFault(stackFault), .c1Flag(c1Flag), .invalidOp(invalidOp)
  );

  // op idx data | expected top tag fault c1 inv | check-read expected-read
  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  idx;
    logic [15:0] dat;
    logic [2:0]  eTop;
    logic [15:0] eTag;
    logic        eSf;
    logic        eC1;
    logic        eInv;
    logic        chkRd;
    logic [15:0] eRd;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd0, 16'h1111, 3'd7, 16'h3FFF, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2
    '{3'd0, 3'd0, 16'h2222, 3'd6, 16'h0FFF, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2
    '{3'd4, 3'd1, 16'h0000, 3'd6, 16'h0FFF, 1'b0, 1'b0, 1'b0, 1'b1, 16'h1111}, // R3
    '{3'd4, 3'd0, 16'h0000, 3'd6, 16'h0FFF, 1'b0, 1'b0, 1'b0, 1'b1, 16'h2222}, // R3
    '{3'd1, 3'd1, 16'h0000, 3'd5, 16'h03FF, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R4
    '{3'd4, 3'd0, 16'h0000, 3'd5, 16'h03FF, 1'b0, 1'b0, 1'b0, 1'b1, 16'h1111}, // R4
    '{3'd3, 3'd1, 16'h0000, 3'd5, 16'h03FF, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R6
    '{3'd4, 3'd0, 16'h0000, 3'd5, 16'h03FF, 1'b0, 1'b0, 1'b0, 1'b1, 16'h2222}, // R6
    '{3'd4, 3'd1, 16'h0000, 3'd5, 16'h03FF, 1'b0, 1'b0, 1'b0, 1'b1, 16'h1111}, // R6
    '{3'd3, 3'd0, 16'h0000, 3'd5, 16'h03FF, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R6 index 0 -> ST1
    '{3'd4, 3'd0, 16'h0000, 3'd5, 16'h03FF, 1'b0, 1'b0, 1'b0, 1'b1, 16'h1111}, // R6
    '{3'd5, 3'd2, 16'h3333, 3'd5, 16'h03FF, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R7
    '{3'd4, 3'd2, 16'h0000, 3'd5, 16'h03FF, 1'b0, 1'b0, 1'b0, 1'b1, 16'h3333}, // R7
    '{3'd2, 3'd1, 16'h0000, 3'd6, 16'h0FFF, 1'b0, 1'b0, 1'b0, 1'b1, 16'h1111}, // R5
    '{3'd4, 3'd0, 16'h0000, 3'd6, 16'h0FFF, 1'b0, 1'b0, 1'b0, 1'b1, 16'h1111}, // R5
    '{3'd2, 3'd0, 16'h0000, 3'd7, 16'h3FFF, 1'b0, 1'b0, 1'b0, 1'b1, 16'h1111}, // R5
    '{3'd4, 3'd0, 16'h0000, 3'd7, 16'h3FFF, 1'b0, 1'b0, 1'b0, 1'b1, 16'h3333}, // R5
    '{3'd4, 3'd3, 16'h0000, 3'd7, 16'h3FFF, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000}, // R9
    '{3'd7, 3'd0, 16'h0000, 3'd7, 16'h3FFF, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R11
    '{3'd2, 3'd0, 16'h0000, 3'd0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b1, 16'h3333}, // R5
    '{3'd2, 3'd0, 16'h0000, 3'd0, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000}, // R9
    '{3'd3, 3'd1, 16'h0000, 3'd0, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000}, // R9
    '{3'd6, 3'd0, 16'h0000, 3'd0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}  // R1
  };

  task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge, after the update
  task automatic doCmd(input logic [2:0] op, input logic [2:0] idx, input logic [15:0] d);
    cmdValid = 1'b1;
    cmdOp    = op;
    cmdIdx   = idx;
    cmdData  = {5{d}};
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  function automatic logic [21:0] status();
    return {topPtr, tagWord, stackFault, c1Flag, invalidOp};
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset status", 128'(status()), 128'({3'd0, 16'hFFFF, 3'b000}));
    chk("R1 reset rdValid", 128'(rdValid), 128'(1'b0));

    for (int v = 0; v < NV; v++) begin
      doCmd(VECS[v].op, VECS[v].idx, VECS[v].dat);
      chk($sformatf("vector %0d status", v), 128'(status()),
          128'({VECS[v].eTop, VECS[v].eTag, VECS[v].eSf, VECS[v].eC1, VECS[v].eInv}));
      if (VECS[v].chkRd)
        chk($sformatf("vector %0d read R3", v), 128'({rdValid, rdData}),
            128'({1'b1, {5{VECS[v].eRd}}}));
    end

    // R8 overflow: fill all eight, then push once more
    doCmd(3'd6, 3'd0, 16'h0);
    for (int k = 0; k < 8; k++) doCmd(3'd0, 3'd0, 16'h00A0 + 16'(k));
    chk("R2 full stack status", 128'(status()), 128'({3'd0, 16'h0000, 3'b000}));
    doCmd(3'd0, 3'd0, 16'hBEEF);
    chk("R8 overflow status", 128'(status()), 128'({3'd0, 16'h0000, 3'b111}));
    doCmd(3'd4, 3'd0, 16'h0);
    chk("R8 top data unchanged", 128'({rdValid, rdData}), 128'({1'b1, {5{16'h00A7}}}));
    @(negedge clk);
    chk("R3 rdValid single pulse", 128'(rdValid), 128'(1'b0));
    doCmd(3'd7, 3'd0, 16'h0);
    chk("R11 clear keeps C1", 128'(status()), 128'({3'd0, 16'h0000, 3'b010}));
    doCmd(3'd3, 3'd1, 16'h0);
    chk("R6 exchange clears C1", 128'(status()), 128'({3'd0, 16'h0000, 3'b000}));

    // R10 simultaneous overflow and underflow on push copy
    doCmd(3'd6, 3'd0, 16'h0);
    doCmd(3'd5, 3'd7, 16'h5A5A);
    chk("R7 write into empty ST7", 128'(status()), 128'({3'd0, 16'h3FFF, 3'b000}));
    doCmd(3'd1, 3'd3, 16'h0);
    chk("R10 overflow wins over underflow", 128'(status()), 128'({3'd0, 16'h3FFF, 3'b111}));

    // R9 push copy from empty source alone
    doCmd(3'd6, 3'd0, 16'h0);
    doCmd(3'd1, 3'd2, 16'h0);
    chk("R9 push copy of empty", 128'(status()), 128'({3'd0, 16'hFFFF, 3'b101}));

    finishRun();
  end
endmodule